// File: doc/BRIEF.md
# Dual-Issue In-Order Completion Buffer

This block tracks instructions between dispatch and register-file writeback in a small out-of-order core. It is a six-entry circular buffer. In each cycle, up to two dispatched instructions claim entries in program order, and each one gets back the index of its entry as a tag. Execution units of different latencies later return results by tag, in any order. A result lands in its entry and marks that entry done.

In each cycle, the oldest entries that are done leave the buffer in program order, at most two at a time. Their destination register numbers and values appear on registered writeback outputs, one slot per register-file write port. A flush input empties the buffer in a single cycle, for example on a branch mispredict.

Top module: `inord_cbuf`

## Requirements
- R1: After a synchronous reset the buffer is empty. Both retire valid bits are 0, `disp_ready` is high for a two-instruction request, and the first two tags offered are 0 and 1.
- R2: Accepted instructions get consecutive entry indices starting at the tail, in lane order. When both lanes are valid, lane 0 is older. A request on lane 1 alone takes the tail index. Indices run 0 to 5 and wrap from 5 to 0.
- R3: `disp_ready` is low when the free entries are fewer than the number of valid lanes. Free entries are six minus the occupancy at the start of the cycle, so entries retiring in that same cycle do not count. Nothing is allocated while `disp_ready` is low, and occupancy never exceeds six.
- R4: A result write stores its value in the tagged entry and marks the entry done. Writes may arrive in any order relative to dispatch.
- R5: Entries retire strictly in program order, at most two per cycle. Slot 0 carries the older entry. Slot 1 is valid only when slot 0 is valid, and an entry never retires before every older entry has retired.
- R6: Retire outputs are registered. A result written at clock edge k can first appear on the retire outputs after edge k+1.
- R7: A result write to an entry that is not valid at the start of the cycle is ignored. This includes an entry being allocated in that same cycle.
- R8: Flush empties the buffer in one cycle. No entry retires at the flush edge or later from the flushed contents. Dispatch and result writes in the flush cycle are ignored, and `disp_ready` is low while flush is high. Afterwards, tags restart at 0.
- R9: When several write ports target the same entry in one cycle, the value from the highest-numbered port is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard every entry this cycle |
| disp_valid | input | 2 | Per-lane dispatch request |
| disp_dst | input | 2x5 | Destination register per lane |
| disp_ready | output | 1 | Request accepted this cycle |
| disp_tag | output | 2x3 | Entry index offered to each lane |
| wb_valid | input | NWB | Result write enable per port |
| wb_tag | input | NWBx3 | Entry index per result port |
| wb_data | input | NWBx32 | Result value per port |
| ret_valid | output | 2 | Retire slot valid, slot 0 older |
| ret_dst | output | 2x5 | Destination register per retire slot |
| ret_data | output | 2x32 | Result value per retire slot |

## Verification
The assertions check the following on every cycle:
- occupancy never goes past six;
- a full buffer never raises ready;
- the two offered tags differ;
- slot 1 never retires without slot 0;
- the head moves by exactly the number of retired entries;
- a flush leaves the buffer empty with nothing retiring.

Only the bench scenarios can show what data leaves the buffer. They check that results written out of order still leave in dispatch order with the right register and value, and that a completed entry stays behind an unfinished older one. They also check that a stale write into a freshly allocated entry is dropped, that the later port wins on a tag collision, and that a done entry is discarded rather than retired when a flush arrives.

// File: rtl/cbuf_pkg.sv
`timescale 1ns/1ps
package cbuf_pkg;
  // Number of dispatch lanes and of retire slots.
  localparam int LANES = 2;

  // Circular index arithmetic for a ring of arbitrary (non power of two) size.
  function automatic int wrap_add(input int p, input int k, input int depth);
    int s;
    s = p + k;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/cbuf_ptr_ctl.sv
`timescale 1ns/1ps
module cbuf_ptr_ctl import cbuf_pkg::*; #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [1:0]    alloc_n,
  input  logic [1:0]    ret_n,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] free_cnt
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      head <= PW'(wrap_add(int'(head), int'(ret_n), DEPTH));
      tail <= PW'(wrap_add(int'(tail), int'(alloc_n), DEPTH));
      occ  <= occ + CW'(alloc_n) - CW'(ret_n);
    end
  end

  assign free_cnt = CW'(DEPTH) - occ;
endmodule

// File: rtl/cbuf_entry_store.sv
`timescale 1ns/1ps
module cbuf_entry_store import cbuf_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int DW    = 32,
  parameter int RW    = 5,
  parameter int NWB   = 2,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [LANES-1:0]        al_en,
  input  logic [LANES-1:0][PW-1:0] al_idx,
  input  logic [LANES-1:0][RW-1:0] al_dst,
  input  logic [NWB-1:0]          wb_en,
  input  logic [NWB-1:0][PW-1:0]  wb_idx,
  input  logic [NWB-1:0][DW-1:0]  wb_data,
  input  logic [LANES-1:0]        rt_en,
  input  logic [LANES-1:0][PW-1:0] rt_idx,
  input  logic [LANES-1:0][PW-1:0] rd_idx,
  output logic [LANES-1:0]        rd_ok,
  output logic [LANES-1:0][RW-1:0] rd_dst,
  output logic [LANES-1:0][DW-1:0] rd_data
);
  localparam int NSLOT = 1 << PW;

  logic [NSLOT-1:0] vld_w;
  logic [NSLOT-1:0] done_w;
  logic [RW-1:0]    dst_w  [NSLOT];
  logic [DW-1:0]    data_w [NSLOT];

  for (genvar e = 0; e < NSLOT; e++) begin : g_ent
    if (e < DEPTH) begin : g_live
      logic          v_q, d_q;
      logic [RW-1:0] dst_q;
      logic [DW-1:0] dat_q;
      logic          al_hit, rt_hit, wb_hit;
      logic [RW-1:0] al_d;
      logic [DW-1:0] wb_d;

      always_comb begin
        al_hit = 1'b0;
        al_d   = '0;
        rt_hit = 1'b0;
        for (int l = 0; l < LANES; l++) begin
          if (al_en[l] && al_idx[l] == PW'(e)) begin
            al_hit = 1'b1;
            al_d   = al_dst[l];
          end
          if (rt_en[l] && rt_idx[l] == PW'(e)) rt_hit = 1'b1;
        end
      end

      // Later ports override earlier ones on a collision.
      always_comb begin
        wb_hit = 1'b0;
        wb_d   = '0;
        for (int p = 0; p < NWB; p++) begin
          if (wb_en[p] && wb_idx[p] == PW'(e)) begin
            wb_hit = 1'b1;
            wb_d   = wb_data[p];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst || flush) begin
          v_q <= 1'b0;
          d_q <= 1'b0;
        end else begin
          if (al_hit) begin
            v_q <= 1'b1;
            d_q <= 1'b0;
          end else if (rt_hit) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
          end
          if (wb_hit && v_q) d_q <= 1'b1;
        end
      end

      // Payload registers carry no reset.
      always_ff @(posedge clk) begin
        if (al_hit) dst_q <= al_d;
        if (wb_hit && v_q && !flush) dat_q <= wb_d;
      end

      assign vld_w[e]  = v_q;
      assign done_w[e] = d_q;
      assign dst_w[e]  = dst_q;
      assign data_w[e] = dat_q;
    end else begin : g_pad
      assign vld_w[e]  = 1'b0;
      assign done_w[e] = 1'b0;
      assign dst_w[e]  = '0;
      assign data_w[e] = '0;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_ok[l]   = vld_w[rd_idx[l]] & done_w[rd_idx[l]];
    assign rd_dst[l]  = dst_w[rd_idx[l]];
    assign rd_data[l] = data_w[rd_idx[l]];
  end
endmodule

// File: rtl/cbuf_retire_sel.sv
`timescale 1ns/1ps
module cbuf_retire_sel import cbuf_pkg::*; #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic [LANES-1:0]         rd_ok,
  input  logic [LANES-1:0][RW-1:0] rd_dst,
  input  logic [LANES-1:0][DW-1:0] rd_data,
  output logic [1:0]               ret_n,
  output logic [LANES-1:0]         ret_go,
  output logic [LANES-1:0]         ret_valid,
  output logic [LANES-1:0][RW-1:0] ret_dst,
  output logic [LANES-1:0][DW-1:0] ret_data
);
  // Slot l may leave only if every older slot leaves in the same cycle.
  always_comb begin
    ret_go[0] = rd_ok[0] && !flush;
    for (int l = 1; l < LANES; l++) ret_go[l] = ret_go[l-1] && rd_ok[l];
    ret_n = '0;
    for (int l = 0; l < LANES; l++) ret_n = ret_n + {1'b0, ret_go[l]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= '0;
      ret_dst   <= '0;
      ret_data  <= '0;
    end else begin
      ret_valid <= ret_go;
      ret_dst   <= rd_dst;
      ret_data  <= rd_data;
    end
  end
endmodule

// File: rtl/inord_cbuf.sv
`timescale 1ns/1ps
module inord_cbuf import cbuf_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int DW    = 32,
  parameter int RW    = 5,
  parameter int NWB   = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [1:0]              disp_valid,
  input  logic [1:0][RW-1:0]      disp_dst,
  output logic                    disp_ready,
  output logic [1:0][PW-1:0]      disp_tag,
  input  logic [NWB-1:0]          wb_valid,
  input  logic [NWB-1:0][PW-1:0]  wb_tag,
  input  logic [NWB-1:0][DW-1:0]  wb_data,
  output logic [1:0]              ret_valid,
  output logic [1:0][RW-1:0]      ret_dst,
  output logic [1:0][DW-1:0]      ret_data
);
  logic [PW-1:0]    head, tail, head1, tail1;
  logic [CW-1:0]    occ, free_cnt;
  logic [1:0]       req_n, alloc_n, ret_n;
  logic [1:0]       al_en, ret_go, rd_ok;
  logic [1:0][PW-1:0] rd_idx;
  logic [1:0][RW-1:0] rd_dst;
  logic [1:0][DW-1:0] rd_data;

  assign head1 = PW'(wrap_add(int'(head), 1, DEPTH));
  assign tail1 = PW'(wrap_add(int'(tail), 1, DEPTH));

  // The first valid lane takes the tail entry, the second takes the next one.
  assign disp_tag[0] = tail;
  assign disp_tag[1] = disp_valid[0] ? tail1 : tail;

  assign req_n      = {1'b0, disp_valid[0]} + {1'b0, disp_valid[1]};
  assign disp_ready = !flush && (free_cnt >= CW'(req_n));
  assign al_en      = disp_valid & {2{disp_ready}};
  assign alloc_n    = disp_ready ? req_n : 2'd0;

  assign rd_idx[0] = head;
  assign rd_idx[1] = head1;

  cbuf_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .alloc_n  (alloc_n),
    .ret_n    (ret_n),
    .head     (head),
    .tail     (tail),
    .occ      (occ),
    .free_cnt (free_cnt)
  );

  cbuf_entry_store #(.DEPTH(DEPTH), .DW(DW), .RW(RW), .NWB(NWB)) u_store (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .al_en   (al_en),
    .al_idx  (disp_tag),
    .al_dst  (disp_dst),
    .wb_en   (wb_valid),
    .wb_idx  (wb_tag),
    .wb_data (wb_data),
    .rt_en   (ret_go),
    .rt_idx  (rd_idx),
    .rd_idx  (rd_idx),
    .rd_ok   (rd_ok),
    .rd_dst  (rd_dst),
    .rd_data (rd_data)
  );

  cbuf_retire_sel #(.DW(DW), .RW(RW)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .rd_ok     (rd_ok),
    .rd_dst    (rd_dst),
    .rd_data   (rd_data),
    .ret_n     (ret_n),
    .ret_go    (ret_go),
    .ret_valid (ret_valid),
    .ret_dst   (ret_dst),
    .ret_data  (ret_data)
  );
endmodule

// File: rtl/cbuf_chk.sv
`timescale 1ns/1ps
module cbuf_chk #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic [1:0]         disp_valid,
  input logic               disp_ready,
  input logic [1:0][PW-1:0] disp_tag,
  input logic [1:0]         ret_valid,
  input logic [CW-1:0]      occ,
  input logic [PW-1:0]      head
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH) && disp_valid != 2'b00) |-> !disp_ready);

  assert_tags_distinct_R2: assert property (@(posedge clk) disable iff (rst)
    (disp_valid == 2'b11) |-> (disp_tag[0] != disp_tag[1]));

  assert_slot_order_R5: assert property (@(posedge clk) disable iff (rst)
    ret_valid[1] |-> ret_valid[0]);

  assert_head_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flush)) |->
      (int'(head) == ((int'($past(head)) + $countones(ret_valid)) % DEPTH)));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0 && ret_valid == 2'b00));
endmodule

bind inord_cbuf cbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .disp_tag   (disp_tag),
  .ret_valid  (ret_valid),
  .occ        (occ),
  .head       (head)
);

// File: tb/sim_inord_cbuf.sv
`timescale 1ns/1ps
module sim_inord_cbuf;
  localparam int DEPTH = 6;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int NWB = 2;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic [1:0]             disp_valid = '0;
  logic [1:0][RW-1:0]     disp_dst = '0;
  logic                   disp_ready;
  logic [1:0][PW-1:0]     disp_tag;
  logic [NWB-1:0]         wb_valid = '0;
  logic [NWB-1:0][PW-1:0] wb_tag = '0;
  logic [NWB-1:0][DW-1:0] wb_data = '0;
  logic [1:0]             ret_valid;
  logic [1:0][RW-1:0]     ret_dst;
  logic [1:0][DW-1:0]     ret_data;

  always #10 clk = ~clk;

  inord_cbuf #(.DEPTH(DEPTH), .DW(DW), .RW(RW), .NWB(NWB)) u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_valid(disp_valid), .disp_dst(disp_dst), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_data(ret_data)
  );

  typedef struct packed { logic [RW-1:0] dst; logic [DW-1:0] data; } exp_t;
  exp_t q[$];
  logic [DW-1:0] tag_data [DEPTH];
  int n_chk = 0;
  int n_fail = 0;
  int seq = 0;
  bit done_run = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    disp_valid = '0;
    wb_valid = '0;
    flush = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic set_wb(input int port, input logic [PW-1:0] t, input logic [DW-1:0] d);
    wb_valid[port] = 1'b1;
    wb_tag[port] = t;
    wb_data[port] = d;
  endtask

  task automatic expect_ret(input logic [1:0] e, input string req);
    check(ret_valid == e, req, 64'(ret_valid), 64'(e));
  endtask

  task automatic peek(input logic [1:0] v, input bit rdy, input logic [PW-1:0] x0, input logic [PW-1:0] x1, input string req);
    disp_valid = v;
    #1;
    check(disp_ready == rdy, req, 64'(disp_ready), 64'(rdy));
    if (rdy) begin
      check(disp_tag[0] == x0, req, 64'(disp_tag[0]), 64'(x0));
      if (v == 2'b11) check(disp_tag[1] == x1, req, 64'(disp_tag[1]), 64'(x1));
    end
    disp_valid = '0;
  endtask

  // Dispatch the valid lanes; x0/x1 are the expected tags of the first/second valid lane.
  task automatic dispatch(input logic [1:0] v, input logic [PW-1:0] x0, input logic [PW-1:0] x1, input string req);
    int k = 0;
    disp_valid = v;
    for (int l = 0; l < 2; l++) disp_dst[l] = RW'(seq + l + 3);
    #1;
    check(disp_ready == 1'b1, req, 64'(disp_ready), 64'd1);
    for (int l = 0; l < 2; l++) begin
      if (v[l]) begin
        logic [PW-1:0] t;
        logic [PW-1:0] x;
        t = disp_tag[l];
        x = (k == 0) ? x0 : x1;
        check(t == x, req, 64'(t), 64'(x));
        tag_data[t] = 32'hC0DE_0000 + DW'(seq);
        q.push_back('{dst: disp_dst[l], data: tag_data[t]});
        seq++;
        k++;
      end
    end
    step();
  endtask

  task automatic complete1(input logic [PW-1:0] t);
    set_wb(0, t, tag_data[t]);
    step();
  endtask

  task automatic complete2(input logic [PW-1:0] t0, input logic [PW-1:0] t1);
    set_wb(0, t0, tag_data[t0]);
    set_wb(1, t1, tag_data[t1]);
    step();
  endtask

  // Scoreboard monitor: every retire slot must match the oldest expected entry.
  always @(negedge clk) begin
    if (!rst) begin
      for (int l = 0; l < 2; l++) begin
        if (ret_valid[l]) begin
          if (q.size() == 0) begin
            check(1'b0, "R5 retire with nothing outstanding", 64'(ret_data[l]), 64'd0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(ret_dst[l] == e.dst, "R5 dst order", 64'(ret_dst[l]), 64'(e.dst));
            check(ret_data[l] == e.data, "R4 R5 data", 64'(ret_data[l]), 64'(e.data));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    expect_ret(2'b00, "R1");
    peek(2'b11, 1'b1, 3'd0, 3'd1, "R1");

    // R2 fill the ring in order
    dispatch(2'b11, 3'd0, 3'd1, "R2");
    dispatch(2'b11, 3'd2, 3'd3, "R2");
    dispatch(2'b11, 3'd4, 3'd5, "R2");
    peek(2'b01, 1'b0, 3'd0, 3'd0, "R3 full");

    // R4 R5 out-of-order completion, in-order retirement
    complete1(3'd3);
    complete1(3'd1);
    expect_ret(2'b00, "R5 head not done");
    step();
    expect_ret(2'b00, "R5 head not done");
    complete1(3'd0);
    expect_ret(2'b00, "R6 no same-cycle retire");
    step();
    expect_ret(2'b11, "R5 R6 two retire");
    step();
    expect_ret(2'b00, "R5 blocked by entry 2");
    complete2(3'd4, 3'd2);
    expect_ret(2'b00, "R6");
    step();
    expect_ret(2'b11, "R5 entries 2,3");
    step();
    expect_ret(2'b01, "R5 entry 4 alone");
    step();
    expect_ret(2'b00, "R5 entry 5 pending");

    // R2 wrap and lone lane 1
    dispatch(2'b11, 3'd0, 3'd1, "R2 wrap");
    dispatch(2'b10, 3'd2, 3'd2, "R2 lane1 alone");

    // R7 stale write to an entry allocated in the same cycle
    set_wb(0, 3'd3, 32'hDEAD_BEEF);
    dispatch(2'b01, 3'd3, 3'd3, "R7");
    complete2(3'd5, 3'd0);
    complete2(3'd1, 3'd2);
    step();
    step();
    step();
    expect_ret(2'b00, "R7 stale write ignored");
    complete1(3'd3);
    step();
    expect_ret(2'b01, "R7 entry 3 after real write");

    // R9 port collision on one tag
    dispatch(2'b01, 3'd4, 3'd4, "R9");
    set_wb(0, 3'd4, ~tag_data[4]);
    set_wb(1, 3'd4, tag_data[4]);
    step();
    step();
    expect_ret(2'b01, "R9 retire");

    // R3 full buffer with a retirement in flight
    dispatch(2'b11, 3'd5, 3'd0, "R3");
    dispatch(2'b11, 3'd1, 3'd2, "R3");
    dispatch(2'b11, 3'd3, 3'd4, "R3");
    peek(2'b01, 1'b0, 3'd0, 3'd0, "R3 full");
    complete2(3'd5, 3'd0);
    peek(2'b01, 1'b0, 3'd0, 3'd0, "R3 retiring slots not free");
    complete2(3'd1, 3'd2);
    complete2(3'd3, 3'd4);
    repeat (4) step();
    check(q.size() == 0, "R5 drained", 64'(q.size()), 64'd0);

    // R8 flush discards a done entry and blocks same-cycle inputs
    dispatch(2'b11, 3'd5, 3'd0, "R8 setup");
    complete1(3'd5);
    flush = 1'b1;
    disp_valid = 2'b11;
    set_wb(0, 3'd0, 32'hBAD0_0001);
    #1;
    check(disp_ready == 1'b0, "R8 ready low in flush", 64'(disp_ready), 64'd0);
    step();
    q.delete();
    expect_ret(2'b00, "R8 no retire at flush");
    peek(2'b11, 1'b1, 3'd0, 3'd1, "R8 tags restart");
    repeat (4) step();
    expect_ret(2'b00, "R8 nothing left");
    dispatch(2'b11, 3'd0, 3'd1, "R8 after flush");
    complete2(3'd1, 3'd0);
    repeat (3) step();
    check(q.size() == 0, "R5 final drain", 64'(q.size()), 64'd0);

    done_run = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule